// File: doc/BRIEF.md
# Multi-Cycle Core Sequencer

This block is the control sequencer of a non-pipelined 32-bit RISC-V integer core. Reset places it in a one-off start-up stage. From there it moves every instruction through the same five stages, one clock each: fetch, decode, execute, memory and write-back. After write-back it returns to fetch.

In each stage the block drives the strobes the datapath needs: program counter update and its source, instruction register capture, the two ALU operand selects, data memory read and write, and register file write with its result source. The strobes depend on the stage, on the 7-bit major opcode of the instruction held in the instruction register, and on a taken flag from a separate branch comparator.

Every instruction spends one cycle in each stage, including stages where it does no work. In those stages its strobes stay low. This gives every instruction a fixed latency of five cycles. The datapath, the ALU operation decode and the funct-field decode are outside this block.

Top module: `cpu_ctrl_fsm`

## Requirements
- R1: While `rst_ni` is low, `stage_o` reads 0 (start-up) and every strobe output is 0. The stage codes are: 0 start-up, 1 fetch, 2 decode, 3 execute, 4 memory, 5 write-back.
- R2: The start-up stage lasts exactly one clock after reset is released and is then followed by fetch. It is reached again only through reset.
- R3: The stage sequence is fetch, decode, execute, memory, write-back, then fetch again, for every opcode, whether or not the opcode is recognised.
- R4: In fetch, `pc_we_o` and `ir_ld_o` are 1 and `pc_sel_o` is 0 (sequential). `ir_ld_o` is 0 in every other stage.
- R5: In execute, the operand selects follow the opcode. `alu_a_sel_o` codes are 0 register, 1 PC, 2 zero; `alu_b_sel_o` codes are 0 register, 1 immediate. The settings are:
  - register-register 0110011: (0,0)
  - immediate arithmetic 0010011, load 0000011, store 0100011 and JALR 1100111: (0,1)
  - branch 1100011, AUIPC 0010111 and JAL 1101111: (1,1)
  - LUI 0110111: (2,1)
  - any other opcode: (0,0)

  Outside execute, both selects are 0.
- R6: `dmem_re_o` is 1 only in the memory stage with opcode 0000011. `dmem_we_o` is 1 only in the memory stage with opcode 0100011.
- R7: `rf_we_o` is 1 only in write-back, and only for opcodes 0110011, 0010011, 0000011, 0110111, 0010111, 1101111 and 1100111. `wb_sel_o` (0 ALU, 1 memory, 2 link PC+4) is 1 for loads, 2 for JAL and JALR, and 0 otherwise.
- R8: In write-back, `pc_we_o` and `pc_sel_o` (1 = ALU target) are both 1 for JAL and JALR. They are also both 1 for branch opcode 1100011 when `br_taken_i` is 1, and 0 when it is 0. `br_taken_i` has no effect for any other opcode or in any other stage.
- R9: An unrecognised opcode causes no write: `rf_we_o`, `dmem_we_o` and `dmem_re_o` stay 0, and `pc_we_o` is 1 only in fetch. The instruction still completes all five stages and returns to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 7 | Major opcode from the instruction register |
| br_taken_i | input | 1 | Branch comparator taken flag |
| stage_o | output | 3 | Current stage code |
| pc_we_o | output | 1 | Program counter write |
| pc_sel_o | output | 1 | Next PC source: 0 PC+4, 1 ALU target |
| ir_ld_o | output | 1 | Instruction register load |
| alu_a_sel_o | output | 2 | ALU operand A select |
| alu_b_sel_o | output | 1 | ALU operand B select |
| dmem_re_o | output | 1 | Data memory read enable |
| dmem_we_o | output | 1 | Data memory write enable |
| rf_we_o | output | 1 | Register file write enable |
| wb_sel_o | output | 2 | Write-back source select |

## Verification
The bench runs every recognised opcode and several unrecognised ones through full instructions, once with the branch flag high in write-back and once with it low. In all the other stages it toggles the flag the opposite way, so a design that sampled the flag in the wrong stage or for a non-branch opcode would write the PC on a spurious cycle. Store and load are checked against each other, because a design that swapped or merged the memory enables would corrupt memory or read on stores. A reset applied mid-instruction must return the sequencer to start-up for exactly one cycle; a design that skipped start-up or repeated it would misalign every later check. The jump opcodes must write the link value, not the ALU result; a wrong write-back select would corrupt the return address.

// File: rtl/cpu_ctrl_pkg.sv
package cpu_ctrl_pkg;
  localparam int OPC_W = 7;
  localparam int STG_W = 3;

  typedef enum logic [STG_W-1:0] {
    ST_INIT   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_DECODE = 3'd2,
    ST_EXEC   = 3'd3,
    ST_MEM    = 3'd4,
    ST_WB     = 3'd5
  } stage_e;

  typedef enum logic [3:0] {
    CL_NONE, CL_REG, CL_IMM, CL_LOAD, CL_STORE,
    CL_BRANCH, CL_LUI, CL_AUIPC, CL_JAL, CL_JALR
  } op_class_e;

  typedef enum logic [1:0] {
    A_RS1  = 2'd0,
    A_PC   = 2'd1,
    A_ZERO = 2'd2
  } alu_a_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_LINK = 2'd2
  } wb_src_e;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

  typedef struct packed {
    logic    pc_we;
    logic    pc_sel;
    logic    ir_ld;
    alu_a_e  alu_a;
    logic    alu_b;
    logic    dm_re;
    logic    dm_we;
    logic    rf_we;
    wb_src_e wb_sel;
  } strobes_t;
endpackage

// File: rtl/ctrl_opdec.sv
module ctrl_opdec
  import cpu_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output op_class_e        cls_o,
  output logic             has_rd_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_REG:    cls_o = CL_REG;
      OPC_IMM:    cls_o = CL_IMM;
      OPC_LOAD:   cls_o = CL_LOAD;
      OPC_STORE:  cls_o = CL_STORE;
      OPC_BRANCH: cls_o = CL_BRANCH;
      OPC_LUI:    cls_o = CL_LUI;
      OPC_AUIPC:  cls_o = CL_AUIPC;
      OPC_JAL:    cls_o = CL_JAL;
      OPC_JALR:   cls_o = CL_JALR;
      default:    cls_o = CL_NONE;
    endcase
  end

  // formats carrying a destination register
  assign has_rd_o = (cls_o != CL_NONE) && (cls_o != CL_STORE) && (cls_o != CL_BRANCH);
endmodule

// File: rtl/ctrl_seq.sv
module ctrl_seq
  import cpu_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output stage_e stage_o
);
  stage_e stage_q, stage_d;

  always_comb begin
    unique case (stage_q)
      ST_INIT:   stage_d = ST_FETCH;
      ST_FETCH:  stage_d = ST_DECODE;
      ST_DECODE: stage_d = ST_EXEC;
      ST_EXEC:   stage_d = ST_MEM;
      ST_MEM:    stage_d = ST_WB;
      ST_WB:     stage_d = ST_FETCH;
      default:   stage_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= ST_INIT;
    else         stage_q <= stage_d;
  end

  assign stage_o = stage_q;

  p_init_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q != ST_INIT) |=> (stage_q != ST_INIT));

  p_step_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q != ST_WB) |=> (3'(stage_q) == 3'($past(stage_q) + 3'd1)));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_WB) |=> (stage_q == ST_FETCH));
endmodule

// File: rtl/ctrl_strobe.sv
module ctrl_strobe
  import cpu_ctrl_pkg::*;
(
  input  stage_e    stage_i,
  input  op_class_e cls_i,
  input  logic      has_rd_i,
  input  logic      br_taken_i,
  output strobes_t  stb_o
);
  logic redirect;

  assign redirect = (cls_i == CL_JAL) || (cls_i == CL_JALR) ||
                    ((cls_i == CL_BRANCH) && br_taken_i);

  always_comb begin
    stb_o = '0;
    unique case (stage_i)
      ST_FETCH: begin
        stb_o.pc_we = 1'b1;
        stb_o.ir_ld = 1'b1;
      end
      ST_EXEC: begin
        unique case (cls_i)
          CL_REG:                      begin stb_o.alu_a = A_RS1;  stb_o.alu_b = 1'b0; end
          CL_IMM, CL_LOAD,
          CL_STORE, CL_JALR:           begin stb_o.alu_a = A_RS1;  stb_o.alu_b = 1'b1; end
          CL_BRANCH, CL_AUIPC, CL_JAL: begin stb_o.alu_a = A_PC;   stb_o.alu_b = 1'b1; end
          CL_LUI:                      begin stb_o.alu_a = A_ZERO; stb_o.alu_b = 1'b1; end
          default:                     begin stb_o.alu_a = A_RS1;  stb_o.alu_b = 1'b0; end
        endcase
      end
      ST_MEM: begin
        stb_o.dm_re = (cls_i == CL_LOAD);
        stb_o.dm_we = (cls_i == CL_STORE);
      end
      ST_WB: begin
        stb_o.rf_we  = has_rd_i;
        stb_o.pc_we  = redirect;
        stb_o.pc_sel = redirect;
        if (has_rd_i) begin
          if (cls_i == CL_LOAD)                             stb_o.wb_sel = WB_MEM;
          else if ((cls_i == CL_JAL) || (cls_i == CL_JALR)) stb_o.wb_sel = WB_LINK;
          else                                              stb_o.wb_sel = WB_ALU;
        end
      end
      default: stb_o = '0;
    endcase
  end
endmodule

// File: rtl/cpu_ctrl_fsm.sv
module cpu_ctrl_fsm
  import cpu_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             br_taken_i,
  output logic [STG_W-1:0] stage_o,
  output logic             pc_we_o,
  output logic             pc_sel_o,
  output logic             ir_ld_o,
  output logic [1:0]       alu_a_sel_o,
  output logic             alu_b_sel_o,
  output logic             dmem_re_o,
  output logic             dmem_we_o,
  output logic             rf_we_o,
  output logic [1:0]       wb_sel_o
);
  stage_e    stage;
  op_class_e cls;
  logic      has_rd;
  strobes_t  stb;

  ctrl_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stage_o (stage)
  );

  ctrl_opdec u_dec (
    .opcode_i (opcode_i),
    .cls_o    (cls),
    .has_rd_o (has_rd)
  );

  ctrl_strobe u_stb (
    .stage_i    (stage),
    .cls_i      (cls),
    .has_rd_i   (has_rd),
    .br_taken_i (br_taken_i),
    .stb_o      (stb)
  );

  assign stage_o     = stage;
  assign pc_we_o     = stb.pc_we;
  assign pc_sel_o    = stb.pc_sel;
  assign ir_ld_o     = stb.ir_ld;
  assign alu_a_sel_o = stb.alu_a;
  assign alu_b_sel_o = stb.alu_b;
  assign dmem_re_o   = stb.dm_re;
  assign dmem_we_o   = stb.dm_we;
  assign rf_we_o     = stb.rf_we;
  assign wb_sel_o    = stb.wb_sel;

  p_ir_fetch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_ld_o |-> (stage_o == ST_FETCH));

  p_mem_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_re_o || dmem_we_o) |-> (stage_o == ST_MEM));

  p_mem_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_re_o && dmem_we_o));

  p_rf_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (stage_o == ST_WB));

  p_pc_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o && (stage_o == ST_WB)) |-> pc_sel_o);

  p_pc_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> ((stage_o == ST_FETCH) || (stage_o == ST_WB)));
endmodule

// File: tb/tb_cpu_ctrl_fsm.sv
module tb_cpu_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] opcode = 7'h00;
  logic       br = 1'b0;
  logic [2:0] stage;
  logic       pc_we, pc_sel, ir_ld, alu_b, dm_re, dm_we, rf_we;
  logic [1:0] alu_a, wb_sel;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_st = 0;

  always #4 clk = ~clk;

  cpu_ctrl_fsm dut (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .br_taken_i(br),
    .stage_o(stage), .pc_we_o(pc_we), .pc_sel_o(pc_sel), .ir_ld_o(ir_ld),
    .alu_a_sel_o(alu_a), .alu_b_sel_o(alu_b), .dmem_re_o(dm_re),
    .dmem_we_o(dm_we), .rf_we_o(rf_we), .wb_sel_o(wb_sel)
  );

  // reference stage tracker
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_st <= 0;
    else if (exp_st == 5 || exp_st == 0) exp_st <= 1;
    else exp_st <= exp_st + 1;
  end

  task automatic chk(string req, string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (st=%0d op=%b br=%0b)",
               req, nm, act, exp, exp_st, opcode, br);
    end
  endtask

  task automatic compare();
    int e_pcwe = 0, e_pcsel = 0, e_ir = 0, e_a = 0, e_b = 0;
    int e_re = 0, e_we = 0, e_rf = 0, e_wb = 0;
    bit known = 1;
    bit has_rd;
    case (opcode)
      7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011, 7'b1100011,
      7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111: known = 1;
      default: known = 0;
    endcase
    has_rd = known && opcode != 7'b0100011 && opcode != 7'b1100011;
    if (rst_n) begin
      case (exp_st)
        1: begin e_pcwe = 1; e_ir = 1; end   // R4
        3: begin                              // R5
          case (opcode)
            7'b0110011: begin e_a = 0; e_b = 0; end
            7'b0010011, 7'b0000011, 7'b0100011, 7'b1100111: begin e_a = 0; e_b = 1; end
            7'b1100011, 7'b0010111, 7'b1101111: begin e_a = 1; e_b = 1; end
            7'b0110111: begin e_a = 2; e_b = 1; end
            default: begin e_a = 0; e_b = 0; end
          endcase
        end
        4: begin                              // R6
          e_re = (opcode == 7'b0000011);
          e_we = (opcode == 7'b0100011);
        end
        5: begin                              // R7, R8
          e_rf = has_rd;
          if (has_rd) e_wb = (opcode == 7'b0000011) ? 1 :
                             (opcode == 7'b1101111 || opcode == 7'b1100111) ? 2 : 0;
          if (opcode == 7'b1101111 || opcode == 7'b1100111 ||
              (opcode == 7'b1100011 && br)) begin e_pcwe = 1; e_pcsel = 1; end
        end
        default: ;
      endcase
    end
    chk(rst_n ? "R3" : "R1", "stage", int'(stage), exp_st);
    chk(known ? "R4/R8" : "R9", "pc_we", int'(pc_we), e_pcwe);
    chk("R8", "pc_sel", int'(pc_sel), e_pcsel);
    chk("R4", "ir_ld", int'(ir_ld), e_ir);
    chk("R5", "alu_a", int'(alu_a), e_a);
    chk("R5", "alu_b", int'(alu_b), e_b);
    chk(known ? "R6" : "R9", "dmem_re", int'(dm_re), e_re);
    chk(known ? "R6" : "R9", "dmem_we", int'(dm_we), e_we);
    chk(known ? "R7" : "R9", "rf_we", int'(rf_we), e_rf);
    chk("R7", "wb_sel", int'(wb_sel), e_wb);
  endtask

  // one instruction: five stages, br set for write-back and inverted elsewhere (R8)
  task automatic run_instr(logic [6:0] op, logic br_wb);
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      if (s == 0) opcode = op;
      br = (exp_st == 5) ? br_wb : ~br_wb;
      #1 compare();
    end
  endtask

  logic [6:0] ops [13] = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011,
                           7'b1100011, 7'b0110111, 7'b0010111, 7'b1101111,
                           7'b1100111, 7'b0001111, 7'b1110011, 7'b0000000,
                           7'b1111111};

  initial begin
    repeat (3) begin @(negedge clk); #1 compare(); end   // R1 reset state
    @(negedge clk); rst_n = 1'b1;
    #1 compare();                                         // R2 start-up lasts one cycle
    for (int i = 0; i < 13; i++) begin
      run_instr(ops[i], 1'b1);
      run_instr(ops[i], 1'b0);
    end
    // R2: mid-instruction reset returns to start-up once
    @(negedge clk); opcode = 7'b1101111; #1 compare();
    @(negedge clk); #1 compare();
    @(negedge clk); rst_n = 1'b0; #1 compare();
    @(negedge clk); #1 compare();
    @(negedge clk); rst_n = 1'b1; #1 compare();
    run_instr(7'b1101111, 1'b0);
    run_instr(7'b0000011, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule